// File: doc/BRIEF.md
# Serial Dual-Converter Write Sequencer

This block runs on the host side of a link to a dual-channel serial converter. Each accepted request does one of two things. A write request carries a 12-bit code and a channel select. The block pulls chip select low and shifts out a 16-bit frame on a serial clock that it derives from the system clock. It then releases chip select and pulses the load strobe of the chosen channel. A reset request sets the preset-select line to the requested level and then pulses the converter's reset line low.

Requests arrive on a valid/ready port. The block samples the request fields once, in the cycle it accepts them. It lowers ready for the whole transaction and raises a one-cycle done pulse when the transaction ends. Every serial-side output comes from a flop. The serial clock rests high and the data line changes only while that clock is low, so the receiver can take each bit on a rising edge.

Top module: `dac_write_seq`

## Requirements
- R1: After reset, these outputs are high: cs_n, sclk, lda_n, ldb_n, rst_dac_n and req_ready. These outputs are low: sdata, done and preset_mid.
- R2: A write request (req_cmd_rst = 0) produces exactly 16 rising sclk edges while cs_n is low. The sdata values at those edges, in order, are four 0 bits followed by req_code from bit 11 down to bit 0.
- R3: sclk is high whenever cs_n is high. Within a frame, each low phase and each high phase of sclk lasts exactly HALF_CLKS system clocks. sdata holds its value while sclk is high.
- R4: cs_n goes low in the cycle after acceptance and stays low for HALF_CLKS cycles before the first falling sclk edge. It returns high HALF_CLKS cycles after the last rising edge.
- R5: Once cs_n is high again, both strobes stay high for exactly GAP_CLKS cycles. Then the selected strobe (req_chan 0 selects lda_n, 1 selects ldb_n) goes low for exactly STROBE_CLKS cycles. The other strobe stays high throughout.
- R6: A strobe is never low while cs_n is low, and no frame starts unless both strobes are high.
- R7: A reset request (req_cmd_rst = 1) drives preset_mid to req_mid in the cycle after acceptance. GAP_CLKS cycles later, rst_dac_n goes low for STROBE_CLKS cycles. cs_n and both strobes stay high throughout, and preset_mid keeps its value afterwards.
- R8: req_ready is low from the cycle after acceptance until the strobe or reset line returns high. A request raised while req_ready is low is ignored and starts no frame.
- R9: done is high for exactly one cycle: the cycle in which the strobe or reset line returns high, with req_ready high again.
- R10: A HALF_CLKS value below 2 behaves as 2, so a frame then holds cs_n low for 2 + 16*4 = 66 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_cmd_rst | input | 1 | 0: write a code, 1: issue a converter reset |
| req_chan | input | 1 | Target channel for a write (0 = A, 1 = B) |
| req_code | input | CODE_W | Code to write |
| req_mid | input | 1 | Preset level for a reset command (1 = mid-scale, 0 = zero) |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, high when idle |
| sdata | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low chip select |
| lda_n | output | 1 | Active-low load strobe, channel A |
| ldb_n | output | 1 | Active-low load strobe, channel B |
| rst_dac_n | output | 1 | Active-low converter reset |
| preset_mid | output | 1 | Preset-select level presented to the converter |

## Verification
The properties assume only that rst_n is asserted before the first check. They place no limits on the request inputs, because the block samples those inputs only when req_ready is high. The stimulus changes req_code, req_chan and req_mid to different values right after each acceptance, and it raises req_valid while the block is busy. This shows that the frame and the preset level depend only on the values captured at acceptance. The bench waits for req_ready before each new request. Its samples are taken on the falling system clock edge, so every registered output is settled when it is read.

// File: rtl/dac_write_seq.sv
module dac_write_seq #(
  parameter int CODE_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int HALF_CLKS   = 4,
  parameter int GAP_CLKS    = 2,
  parameter int STROBE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cmd_rst,
  input  logic              req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_mid,
  output logic              done,
  output logic              sclk,
  output logic              sdata,
  output logic              cs_n,
  output logic              lda_n,
  output logic              ldb_n,
  output logic              rst_dac_n,
  output logic              preset_mid
);

  localparam int PAD_W   = FRAME_W - CODE_W;
  localparam int HALF_E  = (HALF_CLKS < 2) ? 2 : HALF_CLKS;
  localparam int GAP_E   = (GAP_CLKS < 1) ? 1 : GAP_CLKS;
  localparam int STRB_E  = (STROBE_CLKS < 1) ? 1 : STROBE_CLKS;
  localparam int MAXC_A  = (HALF_E > GAP_E) ? HALF_E : GAP_E;
  localparam int MAXC    = (MAXC_A > STRB_E) ? MAXC_A : STRB_E;
  localparam int TW      = $clog2(MAXC + 1);
  localparam int BW      = $clog2(FRAME_W);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP, S_STRB, S_RPRE, S_RLOW
  } st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [BW-1:0]     bitn;
  logic [FRAME_W-1:0] shreg;
  logic              chan;
  logic [FRAME_W-1:0] frame;

  assign frame     = {{PAD_W{1'b0}}, req_code};
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      chan       <= 1'b0;
      done       <= 1'b0;
      sclk       <= 1'b1;
      sdata      <= 1'b0;
      cs_n       <= 1'b1;
      lda_n      <= 1'b1;
      ldb_n      <= 1'b1;
      rst_dac_n  <= 1'b1;
      preset_mid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_cmd_rst) begin
              preset_mid <= req_mid;
              tmr        <= TW'(GAP_E - 1);
              st         <= S_RPRE;
            end else begin
              shreg <= frame;
              chan  <= req_chan;
              bitn  <= '0;
              cs_n  <= 1'b0;
              sdata <= frame[FRAME_W-1];
              tmr   <= TW'(HALF_E - 1);
              st    <= S_SETUP;
            end
          end
        end
        default: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            case (st)
              S_SETUP: begin
                sclk  <= 1'b0;
                sdata <= shreg[FRAME_W-1];
                tmr   <= TW'(HALF_E - 1);
                st    <= S_LOW;
              end
              S_LOW: begin
                sclk <= 1'b1;
                tmr  <= TW'(HALF_E - 1);
                st   <= S_HIGH;
              end
              S_HIGH: begin
                if (bitn == BW'(FRAME_W - 1)) begin
                  cs_n  <= 1'b1;
                  sdata <= 1'b0;
                  tmr   <= TW'(GAP_E - 1);
                  st    <= S_GAP;
                end else begin
                  bitn  <= bitn + 1'b1;
                  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  sdata <= shreg[FRAME_W-2];
                  sclk  <= 1'b0;
                  tmr   <= TW'(HALF_E - 1);
                  st    <= S_LOW;
                end
              end
              S_GAP: begin
                lda_n <= chan;
                ldb_n <= ~chan;
                tmr   <= TW'(STRB_E - 1);
                st    <= S_STRB;
              end
              S_STRB: begin
                lda_n <= 1'b1;
                ldb_n <= 1'b1;
                done  <= 1'b1;
                st    <= S_IDLE;
              end
              S_RPRE: begin
                rst_dac_n <= 1'b0;
                tmr       <= TW'(STRB_E - 1);
                st        <= S_RLOW;
              end
              S_RLOW: begin
                rst_dac_n <= 1'b1;
                done      <= 1'b1;
                st        <= S_IDLE;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dac_write_seq_chk.sv
module dac_write_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic cs_n,
  input logic lda_n,
  input logic ldb_n,
  input logic rst_dac_n,
  input logic preset_mid
);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R3
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(sdata));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lda_n |-> ldb_n);

  // R6
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lda_n || !ldb_n) |-> cs_n);

  // R6
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(lda_n) && $past(ldb_n)));

  // R7
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_dac_n |-> (cs_n && lda_n && ldb_n));

  // R7
  preset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_dac_n |-> $stable(preset_mid));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lda_n && ldb_n && rst_dac_n && cs_n && req_ready));

endmodule

bind dac_write_seq dac_write_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .sclk(sclk), .sdata(sdata), .cs_n(cs_n), .lda_n(lda_n), .ldb_n(ldb_n),
  .rst_dac_n(rst_dac_n), .preset_mid(preset_mid)
);

// File: tb/sim_dac_write_seq.sv
`timescale 1ns/1ps
module sim_dac_write_seq;
  localparam int H0 = 3;
  localparam int G0 = 3;
  localparam int S0 = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, v0, v1, kind, chan, mid;
  logic [11:0] code;
  logic r0, d0, sc0, sd0, cs0, la0, lb0, rs0, pm0;
  logic r1, d1, sc1, sd1, cs1, la1, lb1, rs1, pm1;
  int checks = 0;
  int errors = 0;

  dac_write_seq #(.HALF_CLKS(H0), .GAP_CLKS(G0), .STROBE_CLKS(S0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(r0), .req_cmd_rst(kind),
    .req_chan(chan), .req_code(code), .req_mid(mid), .done(d0), .sclk(sc0),
    .sdata(sd0), .cs_n(cs0), .lda_n(la0), .ldb_n(lb0), .rst_dac_n(rs0), .preset_mid(pm0));

  dac_write_seq #(.HALF_CLKS(1), .GAP_CLKS(1), .STROBE_CLKS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(r1), .req_cmd_rst(kind),
    .req_chan(chan), .req_code(code), .req_mid(mid), .done(d1), .sclk(sc1),
    .sdata(sd1), .cs_n(cs1), .lda_n(la1), .ldb_n(lb1), .rst_dac_n(rs1), .preset_mid(pm1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr0(input bit ch, input logic [11:0] c, input bit poke);
    int n;
    int bad;
    logic [15:0] cap;
    while (!r0) @(negedge clk);
    v0 = 1'b1; kind = 1'b0; chan = ch; code = c;
    @(negedge clk);
    v0 = 1'b0; code = ~c; chan = ~ch;
    chk(!r0 && !cs0, "R8", r0, 0);
    chk(la0 && lb0 && sc0, "R6", {la0, lb0}, 3);
    cap = '0; bad = 0;
    n = 0;
    while (sc0 && n < 1000) begin
      v0 = poke && (n == 0);
      n++;
      @(negedge clk);
    end
    v0 = 1'b0;
    chk(n == H0, "R4", n, H0);
    for (int b = 0; b < 16; b++) begin
      n = 0;
      while (!sc0 && n < 1000) begin
        if (cs0) bad++;
        n++;
        @(negedge clk);
      end
      if (n != H0) bad++;
      cap = {cap[14:0], sd0};
      n = 0;
      while (sc0 && !cs0 && n < 1000) begin
        n++;
        @(negedge clk);
      end
      if (n != H0) bad++;
      if ((b < 15) == cs0) bad++;
    end
    chk(bad == 0, "R3", bad, 0);
    chk(cap == {4'b0, c}, "R2", cap, {4'b0, c});
    n = 0;
    while (la0 && lb0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == G0, "R5", n, G0);
    chk(ch ? (!lb0 && la0) : (!la0 && lb0), "R5", {la0, lb0}, ch ? 2 : 1);
    n = 0;
    while (!(la0 && lb0) && n < 1000) begin
      if (ch ? !la0 : !lb0) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == S0 && bad == 0, "R5", n, S0);
    chk(d0 && r0, "R9", {d0, r0}, 3);
    @(negedge clk);
    chk(!d0, "R9", d0, 0);
    chk(cs0 && r0, "R8", {cs0, r0}, 3);
  endtask

  task automatic rs0_cmd(input bit m);
    int n;
    int bad;
    while (!r0) @(negedge clk);
    v0 = 1'b1; kind = 1'b1; mid = m;
    @(negedge clk);
    v0 = 1'b0; kind = 1'b0; mid = ~m;
    chk(pm0 == m, "R7", pm0, m);
    n = 0; bad = 0;
    while (rs0 && n < 1000) begin
      if (!(cs0 && la0 && lb0)) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == G0, "R7", n, G0);
    n = 0;
    while (!rs0 && n < 1000) begin
      if (!(cs0 && la0 && lb0)) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == S0 && bad == 0, "R7", n, S0);
    chk(d0 && r0, "R9", {d0, r0}, 3);
    repeat (3) @(negedge clk);
    chk(pm0 == m, "R7", pm0, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; v0 = 1'b0; v1 = 1'b0; kind = 1'b0; chan = 1'b0; mid = 1'b0; code = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cs0 && sc0 && la0 && lb0 && rs0 && r0, "R1", {cs0, sc0, la0, lb0, rs0, r0}, 63);
    chk(!sd0 && !d0 && !pm0, "R1", {sd0, d0, pm0}, 0);

    wr0(1'b0, 12'h000, 1'b0);
    wr0(1'b1, 12'hFFF, 1'b1);
    wr0(1'b0, 12'h800, 1'b0);
    wr0(1'b1, 12'h7FF, 1'b0);
    wr0(1'b0, 12'hAAA, 1'b1);
    wr0(1'b1, 12'h555, 1'b0);
    for (int i = 0; i < 512; i++)
      wr0(i[0], 12'((i * 37 + 5) % 4096), (i % 7) == 0);

    rs0_cmd(1'b1);
    rs0_cmd(1'b0);
    rs0_cmd(1'b1);
    wr0(1'b0, 12'h123, 1'b0);

    // R10: HALF_CLKS = 1 clamps to 2
    while (!r1) @(negedge clk);
    v1 = 1'b1; kind = 1'b0; chan = 1'b1; code = 12'h3C5;
    @(negedge clk);
    v1 = 1'b0;
    n = 0;
    while (!cs1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == 66, "R10", n, 66);
    n = 0;
    while (lb1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == 1, "R10", n, 1);
    @(negedge clk);
    chk(lb1 && d1, "R10", {lb1, d1}, 3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule